// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block produces the status outputs that a NOR-style flash memory presents while an internal program or erase job is running. It watches the chip-enable and output-enable read strobes and the read address, and uses per-sector erase-select and protect flags plus busy and suspend indications from the embedded-operation sequencer. It drives two toggle bits, an open-drain ready/busy drive enable, and a select that chooses between status and array data on the read path.

The mode toggle bit (dq6) inverts once per completed read while any embedded job is running. It stops in suspend and when the job ends. The sector toggle bit (dq2) inverts once per completed read whose address lies in a sector marked for erase, both during the erase and while it is suspended. Host software reads both bits to tell which sectors are erasing and whether the erase is active or suspended. When an erase command targets only protected sectors, or a program command targets a protected sector, the block shows busy for a fixed number of cycles (a parameter) and then goes back to array reads.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, dq6 and dq2 are 0, rdyBusyOeN is 1, statusSel is 0 and no guard window is running.
- R2: A read completes on the clock edge where the combined strobe (ceN and oeN both low) was active in the previous cycle and is now inactive, whichever of ceN or oeN went high. While busy (seqBusy high or a guard window running), dq6 inverts exactly once per completed read, at any address.
- R3: While not busy, dq6 keeps its value across completed reads, including erase-suspend with no program running.
- R4: A cmdErase pulse with a nonzero eraseSel in which every selected sector is protected starts a guard window of ERASE_GUARD_CYC cycles, beginning on the cycle after the pulse. During that window the block is busy. If at least one selected sector is unprotected, no window starts.
- R5: A cmdProgram pulse whose address sector is protected starts a guard window of PROG_GUARD_CYC cycles. A cmdProgram pulse to an unprotected sector starts none. If both pulses arrive together, the erase rule wins.
- R6: rdyBusyOeN is 0 (pull the shared net low) exactly while seqBusy is high or a guard window runs, and 1 otherwise.
- R7: dq2 inverts exactly once per completed read whose address sector has its eraseSel bit set, while seqBusy or seqSuspend is high. Otherwise it keeps its value.
- R8: statusSel is 1 while busy, and during suspend when the read address sector has its eraseSel bit set. Otherwise it is 0.
- R9: The sector of an address is its top SECT_W bits, addr[ADDR_W-1 -: SECT_W], and indexes bit positions of eraseSel and protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Read address; also the program target when cmdProgram pulses |
| eraseSel | input | 2**SECT_W | Per-sector selected-for-erase flags |
| protect | input | 2**SECT_W | Per-sector protect flags |
| cmdErase | input | 1 | One-cycle pulse at the final write strobe of an erase command |
| cmdProgram | input | 1 | One-cycle pulse at the final write strobe of a program command |
| seqBusy | input | 1 | Embedded program or erase running, including a program in suspend |
| seqSuspend | input | 1 | Erase is suspended |
| dq6 | output | 1 | Mode toggle bit |
| dq2 | output | 1 | Sector toggle bit |
| rdyBusyOeN | output | 1 | Active-low drive enable for the open-drain ready/busy net |
| statusSel | output | 1 | 1 selects status bits on the read path, 0 selects array data |

## Verification
A wrong guard counter shows at rdyBusyOeN and statusSel on the first cycle where the window should open or close. A toggle flop that misses a flip, or flips twice, shows as a dq6 or dq2 value mismatch on the cycle after the read ends, and it stays wrong from then on because both bits keep their parity. Bad sector decoding shows on the first read whose sector has a different selected or protected state than the sector the wrong address bits point to. The bench reads at both selected and unselected, protected and unprotected sectors so that such a fault shows.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;
  // Strobes sent from the control module to the toggle datapath
  typedef struct packed {
    logic flipMode;    // invert dq6 this edge
    logic flipSector;  // invert dq2 this edge
  } tglStrobe_t;
endpackage

// File: rtl/flash_status_ctrl.sv
`timescale 1ns/1ps
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int SECT_W          = 3,
  parameter int ERASE_GUARD_CYC = 5000,
  parameter int PROG_GUARD_CYC  = 50,
  localparam int NUM_SECT       = 1 << SECT_W,
  localparam int GUARD_W        = $clog2((ERASE_GUARD_CYC > PROG_GUARD_CYC ?
                                          ERASE_GUARD_CYC : PROG_GUARD_CYC) + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SECT-1:0] eraseSel,
  input  logic [NUM_SECT-1:0] protect,
  input  logic                cmdErase,
  input  logic                cmdProgram,
  input  logic                seqBusy,
  input  logic                seqSuspend,
  output tglStrobe_t          strobes,
  output logic                busyAny,
  output logic                statusSel
);
  logic               strobeQ;
  logic               strobeNow;
  logic               readDone;
  logic [GUARD_W-1:0] guardCnt;
  logic               guardActive;
  logic [SECT_W-1:0]  curSector;
  logic               inSelSector;
  logic               eraseAllProt;
  logic               progProt;

  // R9: sector index is the top address bits
  assign curSector   = addr[ADDR_W-1 -: SECT_W];
  assign inSelSector = eraseSel[curSector];

  // R2: read completes when combined strobe drops
  assign strobeNow = ~ceN & ~oeN;
  assign readDone  = strobeQ & ~strobeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= strobeNow;
  end

  // R4 / R5: fake-busy guard windows
  assign eraseAllProt = cmdErase & (|eraseSel) & ((eraseSel & ~protect) == '0);
  assign progProt     = cmdProgram & protect[curSector];
  assign guardActive  = guardCnt != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             guardCnt <= '0;
    else if (eraseAllProt) guardCnt <= GUARD_W'(ERASE_GUARD_CYC);
    else if (progProt)     guardCnt <= GUARD_W'(PROG_GUARD_CYC);
    else if (guardActive)  guardCnt <= guardCnt - 1'b1;
  end

  assign busyAny   = seqBusy | guardActive;
  assign statusSel = busyAny | (seqSuspend & inSelSector);

  always_comb begin
    strobes.flipMode   = readDone & busyAny;
    strobes.flipSector = readDone & (seqBusy | seqSuspend) & inSelSector;
  end
endmodule

// File: rtl/flash_status_dp.sv
`timescale 1ns/1ps
module flash_status_dp
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tglStrobe_t strobes,
  output logic       dq6,
  output logic       dq2
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dq6 <= 1'b0;
      dq2 <= 1'b0;
    end else begin
      if (strobes.flipMode)   dq6 <= ~dq6;
      if (strobes.flipSector) dq2 <= ~dq2;
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int SECT_W          = 3,
  parameter int ERASE_GUARD_CYC = 5000,
  parameter int PROG_GUARD_CYC  = 50,
  localparam int NUM_SECT       = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SECT-1:0] eraseSel,
  input  logic [NUM_SECT-1:0] protect,
  input  logic                cmdErase,
  input  logic                cmdProgram,
  input  logic                seqBusy,
  input  logic                seqSuspend,
  output logic                dq6,
  output logic                dq2,
  output logic                rdyBusyOeN,
  output logic                statusSel
);
  tglStrobe_t strobes;
  logic       busyAny;

  flash_status_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .ERASE_GUARD_CYC(ERASE_GUARD_CYC), .PROG_GUARD_CYC(PROG_GUARD_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addr(addr),
    .eraseSel(eraseSel), .protect(protect), .cmdErase(cmdErase),
    .cmdProgram(cmdProgram), .seqBusy(seqBusy), .seqSuspend(seqSuspend),
    .strobes(strobes), .busyAny(busyAny), .statusSel(statusSel)
  );

  flash_status_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dq6(dq6), .dq2(dq2)
  );

  // R6: open-drain drive enable, low pulls the shared net down
  assign rdyBusyOeN = ~busyAny;
endmodule

// File: rtl/flash_status_chk.sv
`timescale 1ns/1ps
module flash_status_chk #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 3,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                ceN,
  input logic                oeN,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_SECT-1:0] eraseSel,
  input logic [NUM_SECT-1:0] protect,
  input logic                cmdErase,
  input logic                cmdProgram,
  input logic                seqBusy,
  input logic                seqSuspend,
  input logic                dq6,
  input logic                dq2,
  input logic                rdyBusyOeN,
  input logic                statusSel
);
  logic allProtErase;
  assign allProtErase = cmdErase & (|eraseSel) & ((eraseSel & ~protect) == '0);

  assert_dq6_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdyBusyOeN |=> $stable(dq6));

  assert_dq6_flip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyBusyOeN && $past(!ceN && !oeN) && (ceN || oeN)) |=> (dq6 != $past(dq6)));

  assert_erase_guard_R4: assert property (@(posedge clk) disable iff (!rstN)
    allProtErase |=> !rdyBusyOeN);

  assert_prog_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdProgram && protect[addr[ADDR_W-1 -: SECT_W]]) |=> !rdyBusyOeN);

  assert_seqbusy_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqBusy |-> !rdyBusyOeN);

  assert_status_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdyBusyOeN |-> statusSel);

  assert_dq2_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!seqBusy && !seqSuspend) |=> $stable(dq2));
endmodule

bind flash_status_gen flash_status_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (.*);

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
  localparam int ADDR_W = 12;
  localparam int SECT_W = 3;
  localparam int NSEC   = 1 << SECT_W;
  localparam int EG     = 40;
  localparam int PG     = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [NSEC-1:0] eraseSel = '0, protect = '0;
  logic cmdErase = 1'b0, cmdProgram = 1'b0, seqBusy = 1'b0, seqSuspend = 1'b0;
  logic dq6, dq2, rdyBusyOeN, statusSel;

  int checks = 0;
  int fails = 0;
  bit chkOn = 1'b0;

  // reference model state
  bit m6, m2, mStrobeQ;
  int mGuard;

  always #10 clk = ~clk;  // 50 MHz

  flash_status_gen #(.ADDR_W(ADDR_W), .SECT_W(SECT_W),
                     .ERASE_GUARD_CYC(EG), .PROG_GUARD_CYC(PG)) i_flash_status_gen (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addr(addr),
    .eraseSel(eraseSel), .protect(protect), .cmdErase(cmdErase),
    .cmdProgram(cmdProgram), .seqBusy(seqBusy), .seqSuspend(seqSuspend),
    .dq6(dq6), .dq2(dq2), .rdyBusyOeN(rdyBusyOeN), .statusSel(statusSel)
  );

  function automatic int secOf(logic [ADDR_W-1:0] a);  // R9
    return int'(a[ADDR_W-1 -: SECT_W]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m6 = 0; m2 = 0; mStrobeQ = 0; mGuard = 0;
    end else begin
      bit act, done, busy;
      act  = !ceN && !oeN;
      done = mStrobeQ && !act;
      busy = seqBusy || (mGuard > 0);
      if (done && busy) m6 = !m6;
      if (done && (seqBusy || seqSuspend) && eraseSel[secOf(addr)]) m2 = !m2;
      if (cmdErase && eraseSel != 0 && (eraseSel & ~protect) == 0) mGuard = EG;
      else if (cmdProgram && protect[secOf(addr)]) mGuard = PG;
      else if (mGuard > 0) mGuard = mGuard - 1;
      mStrobeQ = act;
    end
  end

  task automatic cmp(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rstN && chkOn) begin
      bit eBusy;
      eBusy = seqBusy || (mGuard > 0);
      cmp(dq6, m6, "R2 R3 R4 R5 dq6");
      cmp(dq2, m2, "R7 R9 dq2");
      cmp(rdyBusyOeN, !eBusy, "R6 R4 R5 rdyBusyOeN");
      cmp(statusSel, eBusy || (seqSuspend && eraseSel[secOf(addr)]), "R8 statusSel");
    end
  end

  task automatic readCycle(input int sec, input int off, input bit byCe);
    @(negedge clk);
    addr = {sec[SECT_W-1:0], off[ADDR_W-SECT_W-1:0]};
    ceN = 0; oeN = 0;
    @(negedge clk);
    if (byCe) ceN = 1; else oeN = 1;
    @(negedge clk);
    ceN = 1; oeN = 1;
  endtask

  task automatic pulseCmd(input bit erase, input int sec);
    @(negedge clk);
    addr = {sec[SECT_W-1:0], {(ADDR_W-SECT_W){1'b0}}};
    if (erase) cmdErase = 1; else cmdProgram = 1;
    @(negedge clk);
    cmdErase = 0; cmdProgram = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    @(posedge clk); #5;
    // R1: reset state
    cmp(dq6, 1'b0, "R1 dq6");
    cmp(dq2, 1'b0, "R1 dq2");
    cmp(rdyBusyOeN, 1'b1, "R1 rdyBusyOeN");
    cmp(statusSel, 1'b0, "R1 statusSel");
    chkOn = 1;

    // R3: idle reads do not toggle
    readCycle(1, 5, 0); readCycle(2, 7, 1);

    // R2 / R7: active erase, sectors 2 and 5 selected
    eraseSel = 8'b0010_0100;
    @(negedge clk); seqBusy = 1;
    for (int i = 0; i < 3; i++) readCycle(0, i, 0);
    readCycle(2, 3, 1); readCycle(5, 9, 0); readCycle(7, 1, 1); readCycle(2, 4, 0);

    // R3 / R7 / R8: erase suspended
    @(negedge clk); seqBusy = 0; seqSuspend = 1;
    readCycle(2, 1, 0); readCycle(3, 1, 0); readCycle(5, 2, 1);

    // R2: program issued during suspend
    @(negedge clk); seqBusy = 1;
    readCycle(4, 0, 0); readCycle(5, 0, 1);
    @(negedge clk); seqBusy = 0; seqSuspend = 0; eraseSel = '0;
    idle(2);

    // R4: erase where every selected sector is protected
    eraseSel = 8'b1000_0010; protect = 8'b1000_0010;
    pulseCmd(1, 0);
    for (int i = 0; i < 4; i++) readCycle(6, i, i % 2);
    idle(EG);
    readCycle(1, 0, 0);

    // R4: partially protected, no guard window
    eraseSel = 8'b1000_0011;
    pulseCmd(1, 0);
    readCycle(0, 3, 0);
    eraseSel = '0;

    // R5: program to protected then unprotected sector
    pulseCmd(0, 1);
    readCycle(1, 2, 0); readCycle(3, 2, 1);
    idle(PG);
    pulseCmd(0, 3);
    readCycle(3, 0, 0);

    // R5: simultaneous pulses, erase rule wins
    eraseSel = 8'b0000_0010;
    @(negedge clk);
    addr = {3'd7, 9'd0}; cmdErase = 1; cmdProgram = 1;
    @(negedge clk); cmdErase = 0; cmdProgram = 0;
    idle(EG + 3);

    chkOn = 0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule